// File: doc/BRIEF.md
# Programming Permission and Busy Controller

This block sits between the serial command front end and the storage array of a small non-volatile memory that also feeds four converter setting latches. For every decoded READ or WRITE it decides whether the array is programmed, whether a converter latch is reloaded, and whether a self-timed programming period starts. It keeps a programming-enable flag, which is set and cleared by two dedicated commands. It also honours an unlock pin that guards only the converter-register region.

The address space has two regions. The low half (top address bit 0) is general memory. The converter registers sit at the first NUM_CH locations of the high half. Any other high-half address has no effect. A converter latch takes the upper LATCH_W bits of the 16-bit data word.

When a write really programs the array, the block starts a timed busy period and drives a status bit on the data pin. While busy it refuses every command. The status stays on the pin after the period ends, until the bus is deselected or a new command begins.

Top module: `nvm_write_guard`

## Requirements
- R1: After reset the programming flag is clear, `status_oe` is 0, and `mem_wr` and `latch_ld` are 0.
- R2: Command code 2 sets the programming flag and code 3 clears it. The flag keeps its value across any number of READ and WRITE commands.
- R3: A WRITE (code 1) to the general region, where address bit 8 is 0, pulses `mem_wr` one cycle after the command, carrying the command's address and data, only if the flag is set. Otherwise it does nothing and shows no status.
- R4: With `dac_unlock` low, a WRITE to a converter register (address 0x100 plus channel) neither loads a latch nor programs the array.
- R5: With `dac_unlock` high and the flag set, a converter WRITE pulses `latch_ld[channel]` with `latch_val` equal to data bits 15:8, and also programs the array.
- R6: With `dac_unlock` high and the flag clear, a converter WRITE loads only the latch. It causes no `mem_wr` and no status output.
- R7: A READ (code 0) of a converter register loads that channel's latch with `mem_rdata[15:8]`, whatever the flag and the pin are. A READ of the general region changes no output.
- R8: After a programming write, `status_oe` is 1 and `status_bit` is 0 for exactly PROG_CYCLES cycles starting with the cycle of the `mem_wr` pulse. Then `status_bit` becomes 1.
- R9: Every command presented while busy is ignored.
- R10: Once ready, `status_oe` stays 1 until `bus_desel` or `cmd_start` is seen. The cycle after that, it is 0.
- R11: Addresses 0x104 to 0x1FF have no effect on any output.
- R12: At most one `latch_ld` bit is set in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | One-cycle strobe for a decoded command |
| cmd_op | input | 2 | 0 READ, 1 WRITE, 2 enable programming, 3 disable programming |
| cmd_addr | input | 9 | Command address |
| cmd_wdata | input | 16 | Write data |
| mem_rdata | input | 16 | Stored word at `cmd_addr`, valid with the strobe |
| dac_unlock | input | 1 | 1 allows converter-region writes |
| bus_desel | input | 1 | Chip select inactive |
| cmd_start | input | 1 | First bit of a new command received |
| mem_wr | output | 1 | Array programming strobe |
| mem_addr | output | 9 | Programming address |
| mem_wdata | output | 16 | Programming data |
| latch_ld | output | 4 | Per-channel latch load enables |
| latch_val | output | 8 | Value for the loaded latch |
| status_bit | output | 1 | 0 busy, 1 ready |
| status_oe | output | 1 | Drive enable for the status on the data pin |

## Verification
The hardest case to reach is a command that arrives in the middle of a busy period. It has to be presented with settings that would otherwise load a latch and program the array. The stimulus therefore waits for each programming write and injects an unlocked converter WRITE partway through the timed period. It then checks that neither strobe appears. Random sequences mix the flag commands, the pin level and the three address classes, so each permission combination is hit many times.

// File: rtl/nwg_pkg.sv
package nwg_pkg;
   typedef enum logic [1:0] {
      OP_READ  = 2'd0,
      OP_WRITE = 2'd1,
      OP_PEN   = 2'd2,
      OP_PDIS  = 2'd3
   } nwg_op_e;

   typedef enum logic [1:0] {
      REG_GENERAL = 2'd0,
      REG_CONV    = 2'd1,
      REG_NONE    = 2'd2
   } nwg_region_e;
endpackage

// File: rtl/nwg_perm_flag.sv
module nwg_perm_flag
   import nwg_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    accept,
   input  nwg_op_e op,
   output logic    prog_en
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prog_en <= 1'b0;
      end else if (accept) begin
         if (op == OP_PEN) begin
            prog_en <= 1'b1;
         end else if (op == OP_PDIS) begin
            prog_en <= 1'b0;
         end
      end
   end

   // R2: the flag moves only on an accepted enable or disable command
   a_r2_flag_stable: assert property (@(posedge clk) disable iff (!rst_n)
      !($past(accept) && ($past(op) == OP_PEN || $past(op) == OP_PDIS))
      |-> $stable(prog_en));
endmodule

// File: rtl/nwg_busy_timer.sv
module nwg_busy_timer #(
   parameter int PROG_CYCLES = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_prog,
   input  logic bus_desel,
   input  logic cmd_start,
   output logic busy,
   output logic status_bit,
   output logic status_oe
);
   localparam int CNT_W = $clog2(PROG_CYCLES + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(PROG_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic             oe_q;

   initial begin
      assert (PROG_CYCLES >= 1) else $error("PROG_CYCLES must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (start_prog) begin
         cnt_q <= LOAD;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         oe_q <= 1'b0;
      end else if (start_prog) begin
         oe_q <= 1'b1;
      end else if ((cnt_q == '0) && (bus_desel || cmd_start)) begin
         oe_q <= 1'b0;
      end
   end

   assign busy       = (cnt_q != '0);
   assign status_bit = (cnt_q == '0);
   assign status_oe  = oe_q;

   // R8: a busy period is always reported on the pin
   a_r8_busy_driven: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> status_oe);
   // R10: the drive is removed only once ready
   a_r10_release_ready: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(status_oe) |-> $past(status_bit));
endmodule

// File: rtl/nwg_dispatch.sv
module nwg_dispatch
   import nwg_pkg::*;
#(
   parameter int ADDR_W  = 9,
   parameter int DATA_W  = 16,
   parameter int NUM_CH  = 4,
   parameter int LATCH_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  nwg_op_e           op,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] rdata,
   input  logic              unlock,
   input  logic              prog_en,
   output logic              start_prog,
   output logic              mem_wr,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [NUM_CH-1:0] latch_ld,
   output logic [LATCH_W-1:0] latch_val
);
   localparam int CH_W = $clog2(NUM_CH);
   localparam int HI_W = ADDR_W - 1 - CH_W;

   nwg_region_e           region;
   logic [CH_W-1:0]       chan;
   logic                  ld_any;
   logic [LATCH_W-1:0]    ld_val;
   logic [NUM_CH-1:0]     ld_vec;

   initial begin
      assert (NUM_CH >= 2 && (1 << CH_W) == NUM_CH) else $error("NUM_CH must be a power of two >= 2");
      assert (HI_W >= 1) else $error("ADDR_W too small for NUM_CH");
      assert (LATCH_W <= DATA_W) else $error("LATCH_W exceeds DATA_W");
   end

   always_comb begin
      chan = addr[CH_W-1:0];
      if (!addr[ADDR_W-1]) begin
         region = REG_GENERAL;
      end else if (addr[ADDR_W-2:CH_W] == '0) begin
         region = REG_CONV;
      end else begin
         region = REG_NONE;
      end
   end

   always_comb begin
      start_prog = 1'b0;
      ld_any     = 1'b0;
      ld_val     = wdata[DATA_W-1 -: LATCH_W];
      if (accept) begin
         case (op)
            OP_WRITE: begin
               if (region == REG_GENERAL) begin
                  start_prog = prog_en;
               end else if (region == REG_CONV && unlock) begin
                  ld_any     = 1'b1;
                  start_prog = prog_en;
               end
            end
            OP_READ: begin
               if (region == REG_CONV) begin
                  ld_any = 1'b1;
                  ld_val = rdata[DATA_W-1 -: LATCH_W];
               end
            end
            default: ;
         endcase
      end
   end

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      assign ld_vec[g] = ld_any && (chan == CH_W'(g));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_wr    <= 1'b0;
         mem_addr  <= '0;
         mem_wdata <= '0;
         latch_ld  <= '0;
         latch_val <= '0;
      end else begin
         mem_wr   <= start_prog;
         latch_ld <= ld_vec;
         if (start_prog) begin
            mem_addr  <= addr;
            mem_wdata <= wdata;
         end
         if (ld_any) begin
            latch_val <= ld_val;
         end
      end
   end

   // R12: one channel at a time
   a_r12_one_latch: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(latch_ld));
   // R3: programming only with the flag set
   a_r3_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> prog_en);
   // R4: a locked converter write never loads a latch
   a_r4_locked: assert property (@(posedge clk) disable iff (!rst_n)
      ((latch_ld != '0) && ($past(op) == OP_WRITE)) |-> $past(unlock));
   // R9: back-to-back programming strobes cannot occur
   a_r9_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |=> !mem_wr);
endmodule

// File: rtl/nvm_write_guard.sv
module nvm_write_guard
   import nwg_pkg::*;
#(
   parameter int ADDR_W      = 9,
   parameter int DATA_W      = 16,
   parameter int NUM_CH      = 4,
   parameter int LATCH_W     = 8,
   parameter int PROG_CYCLES = 100000
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [1:0]         cmd_op,
   input  logic [ADDR_W-1:0]  cmd_addr,
   input  logic [DATA_W-1:0]  cmd_wdata,
   input  logic [DATA_W-1:0]  mem_rdata,
   input  logic               dac_unlock,
   input  logic               bus_desel,
   input  logic               cmd_start,
   output logic               mem_wr,
   output logic [ADDR_W-1:0]  mem_addr,
   output logic [DATA_W-1:0]  mem_wdata,
   output logic [NUM_CH-1:0]  latch_ld,
   output logic [LATCH_W-1:0] latch_val,
   output logic               status_bit,
   output logic               status_oe
);
   nwg_op_e op;
   logic    busy;
   logic    accept;
   logic    prog_en;
   logic    start_prog;

   assign op     = nwg_op_e'(cmd_op);
   assign accept = cmd_valid && !busy;

   nwg_perm_flag u_flag (
      .clk     (clk),
      .rst_n   (rst_n),
      .accept  (accept),
      .op      (op),
      .prog_en (prog_en)
   );

   nwg_dispatch #(
      .ADDR_W  (ADDR_W),
      .DATA_W  (DATA_W),
      .NUM_CH  (NUM_CH),
      .LATCH_W (LATCH_W)
   ) u_disp (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .op         (op),
      .addr       (cmd_addr),
      .wdata      (cmd_wdata),
      .rdata      (mem_rdata),
      .unlock     (dac_unlock),
      .prog_en    (prog_en),
      .start_prog (start_prog),
      .mem_wr     (mem_wr),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .latch_ld   (latch_ld),
      .latch_val  (latch_val)
   );

   nwg_busy_timer #(
      .PROG_CYCLES (PROG_CYCLES)
   ) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_prog (start_prog),
      .bus_desel  (bus_desel),
      .cmd_start  (cmd_start),
      .busy       (busy),
      .status_bit (status_bit),
      .status_oe  (status_oe)
   );

   // R8: a programming strobe opens a busy window on the pin
   a_r8_strobe_busy: assert property (@(posedge clk) disable iff (!rst_n)
      mem_wr |-> (status_oe && !status_bit));
endmodule

// File: tb/nvm_write_guard_tb.sv
module nvm_write_guard_tb;
   localparam int CLK_PERIOD = 10;
   localparam int PROG       = 12;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 1'b0;
   logic [1:0]  cmd_op = 2'd0;
   logic [8:0]  cmd_addr = '0;
   logic [15:0] cmd_wdata = '0;
   logic [15:0] mem_rdata = '0;
   logic        dac_unlock = 1'b1;
   logic        bus_desel = 1'b0;
   logic        cmd_start = 1'b0;
   logic        mem_wr;
   logic [8:0]  mem_addr;
   logic [15:0] mem_wdata;
   logic [3:0]  latch_ld;
   logic [7:0]  latch_val;
   logic        status_bit;
   logic        status_oe;

   int checks = 0;
   int fails  = 0;
   bit model_en = 1'b0;
   bit done = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   nvm_write_guard #(.PROG_CYCLES(PROG)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .mem_rdata(mem_rdata),
      .dac_unlock(dac_unlock), .bus_desel(bus_desel), .cmd_start(cmd_start),
      .mem_wr(mem_wr), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
      .latch_ld(latch_ld), .latch_val(latch_val),
      .status_bit(status_bit), .status_oe(status_oe));

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic bit is_conv(logic [8:0] a);
      return a[8] && (a[7:2] == 6'd0);
   endfunction

   function automatic bit exp_prog(logic [1:0] op, logic [8:0] a, bit unl, bit en);
      if (op != 2'd1 || !en) return 1'b0;
      if (!a[8]) return 1'b1;
      return is_conv(a) && unl;
   endfunction

   function automatic logic [3:0] exp_ld(logic [1:0] op, logic [8:0] a, bit unl);
      if (!is_conv(a)) return 4'd0;
      if (op == 2'd0 || (op == 2'd1 && unl)) return 4'd1 << a[1:0];
      return 4'd0;
   endfunction

   function automatic string tag(logic [1:0] op, logic [8:0] a, bit unl, bit en);
      if (op == 2'd0) return "R7";
      if (op != 2'd1) return "R2";
      if (!a[8]) return "R3";
      if (!is_conv(a)) return "R11";
      if (!unl) return "R4";
      return en ? "R5" : "R6";
   endfunction

   task automatic do_cmd(logic [1:0] op, logic [8:0] a, logic [15:0] wd,
                         logic [15:0] rd, bit unl, bit use_start);
      bit p;
      logic [3:0] eld;
      string t;
      p   = exp_prog(op, a, unl, model_en);
      eld = exp_ld(op, a, unl);
      t   = tag(op, a, unl, model_en);
      @(negedge clk);
      cmd_valid = 1'b1; cmd_op = op; cmd_addr = a; cmd_wdata = wd;
      mem_rdata = rd; dac_unlock = unl;
      @(negedge clk);
      cmd_valid = 1'b0;
      chk({t, " mem_wr"}, 32'(mem_wr), 32'(p));
      chk({t, " latch_ld"}, 32'(latch_ld), 32'(eld));
      if (eld != 4'd0)
         chk({t, " latch_val"}, 32'(latch_val), (op == 2'd0) ? 32'(rd[15:8]) : 32'(wd[15:8]));
      if (p) begin
         chk({t, " mem_addr"}, 32'(mem_addr), 32'(a));
         chk({t, " mem_wdata"}, 32'(mem_wdata), 32'(wd));
      end
      if (op == 2'd2) model_en = 1'b1;
      if (op == 2'd3) model_en = 1'b0;
      if (p) begin
         chk("R8 oe at start", 32'(status_oe), 32'd1);
         chk("R8 busy at start", 32'(status_bit), 32'd0);
         for (int i = 1; i < PROG; i++) begin
            cmd_valid = (i == 2);
            cmd_op = 2'd1; cmd_addr = 9'h101; cmd_wdata = 16'hA5A5; dac_unlock = 1'b1;
            @(negedge clk);
            cmd_valid = 1'b0;
            chk("R8 busy", 32'(status_bit), 32'd0);
            chk("R9 no strobe while busy", 32'({mem_wr, latch_ld}), 32'd0);
         end
         @(negedge clk);
         chk("R8 ready", 32'(status_bit), 32'd1);
         chk("R10 oe held", 32'(status_oe), 32'd1);
         @(negedge clk);
         chk("R10 oe held idle", 32'(status_oe), 32'd1);
         if (use_start) cmd_start = 1'b1; else bus_desel = 1'b1;
         @(negedge clk);
         cmd_start = 1'b0; bus_desel = 1'b0;
         chk("R10 oe released", 32'(status_oe), 32'd0);
      end else begin
         chk({t, " no status"}, 32'(status_oe), 32'd0);
      end
   endtask

   initial begin
      int unsigned seed;
      logic [8:0] a;
      seed = 32'd20240611;
      void'($urandom(seed));
      repeat (3) @(negedge clk);
      chk("R1 oe", 32'(status_oe), 32'd0);
      chk("R1 strobes", 32'({mem_wr, latch_ld}), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1 oe after release", 32'(status_oe), 32'd0);
      // directed: flag clear after reset, general write dropped (R1, R3)
      do_cmd(2'd1, 9'h010, 16'h1234, 16'h0, 1'b1, 1'b0);
      do_cmd(2'd1, 9'h102, 16'hC300, 16'h0, 1'b1, 1'b0);          // R6
      do_cmd(2'd2, 9'h000, 16'h0, 16'h0, 1'b1, 1'b0);             // R2
      do_cmd(2'd0, 9'h020, 16'h0, 16'hFFFF, 1'b0, 1'b0);          // R7 general read
      do_cmd(2'd1, 9'h0FF, 16'hBEEF, 16'h0, 1'b0, 1'b1);          // R3 persists
      do_cmd(2'd1, 9'h103, 16'h7E00, 16'h0, 1'b0, 1'b0);          // R4
      do_cmd(2'd1, 9'h100, 16'h8100, 16'h0, 1'b1, 1'b0);          // R5
      do_cmd(2'd1, 9'h104, 16'h5555, 16'h0, 1'b1, 1'b0);          // R11
      do_cmd(2'd1, 9'h1FF, 16'h5555, 16'h0, 1'b1, 1'b0);          // R11
      do_cmd(2'd0, 9'h101, 16'h0, 16'h3CAA, 1'b0, 1'b0);          // R7
      do_cmd(2'd3, 9'h000, 16'h0, 16'h0, 1'b1, 1'b0);             // R2
      do_cmd(2'd1, 9'h055, 16'h0F0F, 16'h0, 1'b1, 1'b0);          // R3 disabled
      for (int n = 0; n < 400; n++) begin
         case ($urandom % 3)
            0: a = 9'($urandom % 256);
            1: a = 9'h100 + 9'($urandom % 4);
            default: a = 9'h104 + 9'($urandom % 252);
         endcase
         do_cmd(2'($urandom), a, 16'($urandom), 16'($urandom),
                1'($urandom), 1'($urandom));
      end
      done = 1'b1;
   end

   initial begin
      for (int c = 0; c < 150000; c++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         checks++; fails++;
         $display("FAIL watchdog actual=timeout expected=done");
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule